// File: doc/BRIEF.md
# Device Command Mailbox

This block sits between a host register bus and a device's low-level command engine. To issue a command, the host first places an opcode in a command word. It then clears the done flag and writes 1 to a doorbell. The block latches the opcode when the doorbell is written and runs it through a small executor with a fixed latency. When the command ends, the block writes a one-byte completion code and sets the done flag, which the host polls. Writing 0 to the doorbell while a command runs aborts it. The block then returns to idle and never sets done for the aborted command.

Next to the mailbox the block keeps two liveness indicators. The first is a firmware status byte that carries a running flag and a generation count. The generation count advances on every device reset. The second is a 32-bit heartbeat that counts up once per programmable number of clocks. A halt control puts the block in a simulated dead state. In that state the heartbeat freezes, the running flag reads 0 and doorbells are not acted on.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset these registers read 0: doorbell/busy (address 0), done (address 1), command word (address 2), completion code (address 3) and halt control (address 7). Firmware status (address 4) reads 0x80 and heartbeat period (address 6) reads HB_PER_RST, which is 16 by default.
- R2: When the block is idle and not halted, a write with bit 0 set to the doorbell (address 0) starts the command whose opcode is in bits 7:0 of the command word. Opcodes 0 (no-op), 1 (identify), 2 (device reset) and 3 (init) complete CMD_LAT clocks after the doorbell write with completion code 0 and done bit 0 set.
- R3: Any opcode above 5 completes one clock after the doorbell write with completion code 2.
- R4: Opcodes 4 (image download) and 5 (image control) complete after CMD_LAT clocks with completion code 9 (try again).
- R5: Writing to the done register clears the done bit, whatever data is written. Only a completing command sets it.
- R6: While a command is busy, a doorbell write of 1 is ignored and a change to the command word does not alter the running command. The running command completes at its original time with its original code.
- R7: A doorbell write of 0 while busy returns the block to idle on the next clock. The done bit and the completion code are left unchanged.
- R8: When opcode 2 completes, the generation field advances by one modulo 2^GEN_W and the heartbeat counter and its prescaler are cleared.
- R9: The firmware status byte has the running flag in bit 7 (1 when not halted), the generation in bits GEN_W-1:0 and 0 in every other bit. It never reads 0xFF.
- R10: While not halted, the heartbeat (address 5) advances by one every P clocks, where P is the period register (a value of 0 acts as 1).
- R11: While halt control bit 0 is 1, the heartbeat holds its value and doorbell writes start no command.
- R12: The bus accepts a request in every cycle (req_ready is 1). A read returns its data with rsp_valid one clock after the request. Bit 0 of address 0 reads 1 while a command is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address of the register |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |

## Verification
If the executor's latency counter or its opcode latch is wrong, the host sees it at the done register. The done bit rises a clock early or late, or the completion code differs, and the bench catches this by reading done exactly one clock before and at the expected completion. If the idle/busy state is wrong, an ignored doorbell restarts a command or an abort still sets done. Both show up within CMD_LAT clocks as a busy readback or a done bit that should not be there. A wrong heartbeat prescaler or generation counter shows up as a heartbeat difference between two reads a known number of clocks apart, or as a generation value after a reset that does not match the count of resets.

// File: rtl/mbx_pkg.sv
// Shared constants for the command mailbox: opcodes, completion codes
// and the register word addresses decoded by the top module.
package mbx_pkg;

    localparam logic [7:0] OP_NOP      = 8'd0;
    localparam logic [7:0] OP_IDENTIFY = 8'd1;
    localparam logic [7:0] OP_RESET    = 8'd2;
    localparam logic [7:0] OP_INIT     = 8'd3;
    localparam logic [7:0] OP_IMG_DL   = 8'd4;
    localparam logic [7:0] OP_IMG_CTL  = 8'd5;

    localparam logic [7:0] CC_OK       = 8'd0;
    localparam logic [7:0] CC_BAD_OP   = 8'd2;
    localparam logic [7:0] CC_RETRY    = 8'd9;

    localparam int A_DBELL = 0;
    localparam int A_DONE  = 1;
    localparam int A_CMD   = 2;
    localparam int A_COMP  = 3;
    localparam int A_FWST  = 4;
    localparam int A_HBEAT = 5;
    localparam int A_HBPER = 6;
    localparam int A_CTRL  = 7;

    typedef enum logic {EX_IDLE, EX_BUSY} ex_state_t;

endpackage

// File: rtl/mbx_exec.sv
// Command executor. Latches the opcode on start and counts down a fixed
// latency; unknown opcodes finish after one clock. Assumes start is only
// raised while idle and abort only while busy (the top gates both).
module mbx_exec
    import mbx_pkg::*;
#(
    parameter int CMD_LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic [7:0] opcode,
    output logic       busy,
    output logic       done_set,
    output logic [7:0] cc,
    output logic       reset_fire
);
    localparam int CNT_W = $clog2(CMD_LAT + 1);

    ex_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       op_q;
    logic             known;

    assign known = (opcode <= OP_IMG_CTL);

    // Sequence idle/busy and the latency countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= EX_IDLE;
            cnt   <= '0;
            op_q  <= '0;
        end else if (state == EX_IDLE) begin
            if (start) begin
                state <= EX_BUSY;
                op_q  <= opcode;
                cnt   <= known ? CNT_W'(CMD_LAT - 1) : '0;
            end
        end else if (abort || cnt == '0) begin
            state <= EX_IDLE;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy     = (state == EX_BUSY);
    assign done_set = busy && (cnt == '0) && !abort;

    // Completion code of the latched opcode.
    always_comb begin
        if (op_q == OP_IMG_DL || op_q == OP_IMG_CTL) cc = CC_RETRY;
        else if (op_q > OP_IMG_CTL)                  cc = CC_BAD_OP;
        else                                         cc = CC_OK;
    end

    assign reset_fire = done_set && (op_q == OP_RESET);

endmodule

// File: rtl/mbx_heartbeat.sv
// Liveness counter: advances once every 'period' clocks while run is high.
// A period of zero behaves as one. clear zeroes counter and prescaler.
module mbx_heartbeat #(
    parameter int HB_W  = 32,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PER_W-1:0] period,
    output logic [HB_W-1:0]  beat
);
    logic [PER_W-1:0] pre;
    logic [PER_W-1:0] last;

    assign last = (period == '0) ? '0 : period - 1'b1;

    // Prescale the clock and bump the beat count at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre  <= '0;
            beat <= '0;
        end else if (run) begin
            if (pre >= last) begin
                pre  <= '0;
                beat <= beat + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmd_mailbox.sv
// Command mailbox top: register decode, done/completion registers,
// generation and halt state, and the read path. Assumes one bus request
// per clock; every request is accepted. GEN_W must not exceed 6.
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32,
    parameter int CMD_LAT    = 4,
    parameter int GEN_W      = 4,
    parameter int HB_PER_W   = 16,
    parameter int HB_PER_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int HB_W = 32;

    logic                wr, rd, wr_db;
    logic                start, abort;
    logic                busy, done_set, reset_fire;
    logic [7:0]          cc;
    logic [DATA_W-1:0]   cmd_q;
    logic                done_q;
    logic [7:0]          comp_q;
    logic [GEN_W-1:0]    gen_q;
    logic                halted;
    logic [HB_PER_W-1:0] per_q;
    logic [HB_W-1:0]     hb;
    logic [7:0]          fw_status;
    logic [7:0]          opcode;

    assign req_ready = 1'b1;
    assign wr        = req_valid && req_write;
    assign rd        = req_valid && !req_write;
    assign wr_db     = wr && (req_addr == ADDR_W'(A_DBELL));
    assign start     = wr_db && req_wdata[0] && !busy && !halted;
    assign abort     = wr_db && !req_wdata[0] && busy;
    assign opcode    = cmd_q[7:0];

    mbx_exec #(.CMD_LAT(CMD_LAT)) u_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .opcode(opcode), .busy(busy), .done_set(done_set), .cc(cc),
        .reset_fire(reset_fire)
    );

    mbx_heartbeat #(.HB_W(HB_W), .PER_W(HB_PER_W)) u_hb (
        .clk(clk), .rst_n(rst_n), .run(!halted), .clear(reset_fire),
        .period(per_q), .beat(hb)
    );

    // Host-writable registers: command word, period, halt control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            per_q  <= HB_PER_W'(HB_PER_RST);
            halted <= 1'b0;
        end else if (wr) begin
            if (req_addr == ADDR_W'(A_CMD))   cmd_q  <= req_wdata;
            if (req_addr == ADDR_W'(A_HBPER)) per_q  <= req_wdata[HB_PER_W-1:0];
            if (req_addr == ADDR_W'(A_CTRL))  halted <= req_wdata[0];
        end
    end

    // Done flag and completion code: set by the executor, cleared by host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            comp_q <= '0;
        end else if (done_set) begin
            done_q <= 1'b1;
            comp_q <= cc;
        end else if (wr && req_addr == ADDR_W'(A_DONE)) begin
            done_q <= 1'b0;
        end
    end

    // Generation advances on each completed device reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          gen_q <= '0;
        else if (reset_fire) gen_q <= gen_q + 1'b1;
    end

    // Status byte: running flag on top, generation at the bottom.
    always_comb begin
        fw_status            = '0;
        fw_status[7]         = !halted;
        fw_status[GEN_W-1:0] = gen_q;
    end

    // Registered read path, one clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd;
            case (int'(req_addr))
                A_DBELL: rsp_rdata <= DATA_W'(busy);
                A_DONE:  rsp_rdata <= DATA_W'(done_q);
                A_CMD:   rsp_rdata <= cmd_q;
                A_COMP:  rsp_rdata <= DATA_W'(comp_q);
                A_FWST:  rsp_rdata <= DATA_W'(fw_status);
                A_HBEAT: rsp_rdata <= DATA_W'(hb);
                A_HBPER: rsp_rdata <= DATA_W'(per_q);
                A_CTRL:  rsp_rdata <= DATA_W'(halted);
                default: rsp_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/mbx_checker.sv
// Temporal checks on the mailbox, attached to every cmd_mailbox instance.
module mbx_checker #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              busy,
    input logic              done_q,
    input logic              done_set,
    input logic [7:0]        cc,
    input logic              halted,
    input logic [31:0]       hb,
    input logic [7:0]        fw_status,
    input logic [7:0]        opcode
);
    logic db_wr;
    assign db_wr = req_valid && req_write && (req_addr == '0);

    // R2: done only rises at the end of a busy period.
    p_done_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy));

    // R3: an unknown opcode finishes on the clock after its doorbell.
    p_bad_op_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr && req_wdata[0] && !busy && !halted && opcode > 8'd5)
        |=> (done_set && cc == 8'd2));

    // R6: a second doorbell while busy does not end the command.
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && db_wr && req_wdata[0] && !done_set) |=> busy);

    // R7: abort leaves done untouched and drops busy.
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && db_wr && !req_wdata[0]) |=> (!busy && $stable(done_q)));

    // R9: the status byte is never the invalid all-ones value.
    p_fw_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fw_status != 8'hFF);

    // R11: a halted block keeps its heartbeat frozen.
    p_hb_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !done_set) |=> $stable(hb));

    // R12: reads answer one clock later.
    p_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

bind cmd_mailbox mbx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .busy(busy), .done_q(done_q), .done_set(done_set), .cc(cc),
    .halted(halted), .hb(hb), .fw_status(fw_status), .opcode(opcode)
);

// File: tb/sim_cmd_mailbox.sv
// Directed bench for cmd_mailbox: one task per scenario.
module sim_cmd_mailbox;
    localparam int LAT = 4;
    localparam int GEN_MOD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cmd_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h, expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 3'(a);
        @(negedge clk);
        req_valid = 1'b0;
        if (rsp_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL R12: got rsp_valid=%b, expected 1", rsp_valid);
        end
        d = rsp_rdata;
    endtask

    task automatic ring(input logic [7:0] op);
        bus_wr(1, 0);
        bus_wr(2, {24'd0, op});
        bus_wr(0, 1);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R12 ready", {31'd0, req_ready}, 1);
        bus_rd(0, d); check("R1 busy", d, 0);
        bus_rd(1, d); check("R1 done", d, 0);
        bus_rd(2, d); check("R1 cmd", d, 0);
        bus_rd(3, d); check("R1 comp", d, 0);
        bus_rd(4, d); check("R1 fwstat", d, 32'h80);
        bus_rd(6, d); check("R1 period", d, 16);
        bus_rd(7, d); check("R1 ctrl", d, 0);
    endtask

    task automatic t_latency(input logic [7:0] op, input logic [31:0] cc, input string tag);
        logic [31:0] d;
        ring(op);
        repeat (LAT - 1) @(negedge clk);
        bus_rd(1, d); check({tag, " early"}, d, 0);
        bus_rd(1, d); check({tag, " done"}, d, 1);
        bus_rd(3, d); check({tag, " code"}, d, cc);
    endtask

    task automatic t_bad_op();
        logic [31:0] d;
        ring(8'h40);
        bus_rd(1, d); check("R3 early", d, 0);
        bus_rd(1, d); check("R3 done", d, 1);
        bus_rd(3, d); check("R3 code", d, 2);
    endtask

    task automatic t_done_clear();
        logic [31:0] d;
        bus_wr(1, 1);
        bus_rd(1, d); check("R5 clear by write of 1", d, 0);
        repeat (3) @(negedge clk);
        bus_rd(1, d); check("R5 stays clear", d, 0);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        ring(8'd0);
        bus_wr(0, 0);
        bus_wr(2, 0);
        bus_rd(0, d); check("R7 idle after abort", d, 0);
        repeat (2 * LAT) @(negedge clk);
        bus_rd(1, d); check("R7 no done", d, 0);
        bus_rd(3, d); check("R7 code kept", d, 2);
    endtask

    task automatic t_ignore_busy();
        logic [31:0] d;
        ring(8'd0);
        bus_wr(2, 32'h77);
        bus_wr(0, 1);
        repeat (LAT) @(negedge clk);
        bus_rd(1, d); check("R6 done at original time", d, 1);
        bus_rd(3, d); check("R6 original code", d, 0);
        bus_rd(0, d); check("R6 no restart", d, 0);
    endtask

    task automatic do_reset_cmd();
        logic [31:0] d;
        ring(8'd2);
        repeat (LAT + 1) @(negedge clk);
        bus_rd(1, d); check("R2 reset done", d, 1);
    endtask

    task automatic t_reset_gen();
        logic [31:0] g0, d;
        bus_wr(6, 2);
        repeat (200) @(negedge clk);
        bus_wr(6, 1000);
        bus_rd(4, g0);
        do_reset_cmd();
        bus_rd(5, d); check("R8 heartbeat cleared", d, 0);
        bus_rd(4, d); check("R8 gen+1", d, 32'h80 | ((g0 + 1) % GEN_MOD));
        for (int i = 0; i < GEN_MOD; i++) do_reset_cmd();
        bus_rd(4, d); check("R8 gen wrap", d, 32'h80 | ((g0 + 1) % GEN_MOD));
        check("R9 reserved bits", d & 32'h70, 0);
    endtask

    task automatic t_heartbeat(input int p, input int m);
        logic [31:0] h1, h2;
        bus_wr(6, p);
        bus_rd(5, h1);
        repeat (p * m - 1) @(negedge clk);
        bus_rd(5, h2);
        check("R10 beat count", h2 - h1, m);
    endtask

    task automatic t_halt();
        logic [31:0] h1, h2, d;
        bus_wr(6, 1);
        bus_wr(7, 1);
        bus_rd(4, d); check("R9 running low when halted", d & 32'h80, 0);
        bus_rd(5, h1);
        repeat (20) @(negedge clk);
        bus_rd(5, h2); check("R11 frozen", h2, h1);
        ring(8'd0);
        bus_rd(0, d); check("R11 no start", d, 0);
        repeat (2 * LAT) @(negedge clk);
        bus_rd(1, d); check("R11 no done", d, 0);
        bus_wr(7, 0);
        bus_rd(4, d); check("R9 running restored", d & 32'h80, 32'h80);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_latency(8'd0, 0, "R2 nop");
        t_latency(8'd1, 0, "R2 identify");
        t_latency(8'd3, 0, "R2 init");
        t_latency(8'd4, 9, "R4 download");
        t_latency(8'd5, 9, "R4 control");
        t_done_clear();
        t_bad_op();
        t_abort();
        t_ignore_busy();
        t_reset_gen();
        t_heartbeat(3, 5);
        t_heartbeat(7, 3);
        t_halt();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule